// File: doc/BRIEF.md
# HDB3 Line Code Violation Counter

This block watches a received bipolar line, one symbol per bit period, with a positive-pulse flag and a negative-pulse flag qualified by a bit strobe. It looks for real coding errors. Under plain AMI rules, two pulses of the same polarity in a row are an error. Under HDB3 rules, a same-polarity pulse is accepted when it completes a valid zero-substitution pattern. The block can also count runs of zeros that are too long. The limit on the run depends on the line code.

Each error adds one to a 16-bit counter. The host writes the counter a byte at a time. Lower bytes wait in a staging register until the top byte arrives, and the whole count is then loaded at once. When frame alignment is lost and the hold option is on, counting stops. Two interrupt strobes, each with its own enable, report every advance of the count and every wrap of the count to zero.

Top module: `lcv_monitor`

## Requirements
- R1: After reset, `count` is 0, and `irq_lsb` and `irq_wrap` are both low.
- R2: With `hdb3_en` low, a pulse whose polarity matches the previous pulse adds one to `count`. A pulse that alternates with the previous pulse adds nothing. The first pulse after reset never counts.
- R3: With `hdb3_en` high, a same-polarity pulse is accepted and not counted when two conditions hold: exactly 2 or exactly 3 zero bits sit between it and the previous pulse, and its polarity is opposite to the previous same-polarity pulse (or no such pulse has occurred since reset). Every other same-polarity pulse is counted. Every same-polarity pulse, accepted or counted, becomes the new reference polarity.
- R4: A bit with both `rx_pos` and `rx_neg` high adds one to `count`. It ends any zero run and leaves the last-pulse polarity unchanged.
- R5: With `exz_en` high, a run of zero bits adds one to `count` exactly once, on the bit that makes the run longer than 3 (with `hdb3_en` high) or longer than 15 (with `hdb3_en` low). With `exz_en` low, zero runs never count.
- R6: `count` advances by at most one per bit period, even when a violation and an excess-zero condition fall together.
- R7: While `oof_hold_en` and `sync_lost` are both high, `count` does not advance. Violation tracking carries on.
- R8: A host write with `wr_sel`=0 only stages `wr_data` and leaves `count` unchanged. A write with `wr_sel`=1 loads `count` with {`wr_data`, staged byte}. In that cycle the load wins over any counted event, and no interrupt strobe is raised.
- R9: Each time `count` advances, `irq_lsb` is high for exactly that one cycle, together with the new count, if `lsb_irq_en` is high. If `lsb_irq_en` is low, `irq_lsb` stays low.
- R10: When `count` advances from FFFFh to 0000h, `irq_wrap` is high for that one cycle if `wrap_irq_en` is high.
- R11: While `bit_en` is low, the pulse inputs are ignored and `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Marks a clock cycle that carries one received bit |
| rx_pos | input | 1 | Positive pulse received in this bit |
| rx_neg | input | 1 | Negative pulse received in this bit |
| hdb3_en | input | 1 | 1 selects HDB3 rules, 0 selects plain AMI rules |
| exz_en | input | 1 | Also count excess-zero runs |
| oof_hold_en | input | 1 | Allow counting to be held while frame sync is lost |
| sync_lost | input | 1 | Frame synchronisation is lost |
| wr_en | input | 1 | Host byte write strobe |
| wr_sel | input | 1 | Byte select: 0 for the low (staged) byte, 1 for the high byte (commits the load) |
| wr_data | input | 8 | Host write data |
| lsb_irq_en | input | 1 | Enables the per-advance interrupt strobe |
| wrap_irq_en | input | 1 | Enables the wrap interrupt strobe |
| count | output | 16 | Error count |
| irq_lsb | output | 1 | One-cycle strobe when the count advances |
| irq_wrap | output | 1 | One-cycle strobe when the count wraps to zero |

## Verification
The bench covers four groups of cases.

- **Substitution patterns:** B00V and 000V patterns, a substitution that repeats the previous violation's polarity, and back-to-back same-polarity pulses. A detector that ignored the alternation rule or the zero spacing would either miss real errors or count valid substitutions.
- **Zero runs:** runs just past each threshold and runs far past it. A design that compared against the wrong limit, or counted every extra zero, would move the count on the wrong bit or more than once per run.
- **Byte loads and holds:** a high-byte load that collides with a counted event, and a low-byte-only write. A design that let the event win, or loaded the count from the low byte alone, would show a wrong value right after the write. A counter that ignored the hold or the bit strobe would drift during the gated periods.
- **Wrap:** a preset to FFFFh followed by one event. A design that used the wrong wrap condition or ignored the interrupt enables would show the error on the strobes.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
   // one received symbol, encoded as {negative, positive}
   typedef enum logic [1:0] {
      SYM_ZERO = 2'b00,
      SYM_POS  = 2'b01,
      SYM_NEG  = 2'b10,
      SYM_BOTH = 2'b11
   } lcv_sym_e;

   function automatic lcv_sym_e lcv_sym(input logic p, input logic n);
      return lcv_sym_e'({n, p});
   endfunction
endpackage

// File: rtl/lcv_zero_run.sv
module lcv_zero_run
   import lcv_pkg::*;
#(
   parameter int HDB3_ZMAX = 3,
   parameter int AMI_ZMAX  = 15,
   localparam int ZSAT     = AMI_ZMAX + 1,
   localparam int ZW       = $clog2(ZSAT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  lcv_sym_e      sym,
   input  logic          hdb3_en,
   output logic [ZW-1:0] zrun,
   output logic          exz_hit
);
   generate
      if (HDB3_ZMAX < 3 || HDB3_ZMAX >= AMI_ZMAX) begin : g_bad_thr
         $error("lcv_zero_run: need 3 <= HDB3_ZMAX < AMI_ZMAX");
      end
   endgenerate

   logic [ZW-1:0] thr;
   assign thr     = hdb3_en ? ZW'(HDB3_ZMAX) : ZW'(AMI_ZMAX);
   // this zero lengthens the run from thr to thr+1: first bit over the limit
   assign exz_hit = bit_en && (sym == SYM_ZERO) && (zrun == thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zrun <= '0;
      end else if (bit_en) begin
         if (sym != SYM_ZERO)          zrun <= '0;
         else if (zrun != ZW'(ZSAT))   zrun <= zrun + 1'b1;
      end
   end
endmodule

// File: rtl/lcv_bpv_detect.sv
module lcv_bpv_detect
   import lcv_pkg::*;
#(
   parameter int ZW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  lcv_sym_e      sym,
   input  logic          hdb3_en,
   input  logic [ZW-1:0] zrun,
   output logic          bpv
);
   logic have_p, last_neg, have_v, v_neg;
   logic is_pulse, pol_neg, same, legit;

   assign is_pulse = (sym == SYM_POS) || (sym == SYM_NEG);
   assign pol_neg  = (sym == SYM_NEG);
   assign same     = is_pulse && have_p && (pol_neg == last_neg);
   // a substitution closes 2 or 3 zeros after its partner and alternates with the previous one
   assign legit    = hdb3_en && ((zrun == ZW'(2)) || (zrun == ZW'(3)))
                     && (!have_v || (pol_neg != v_neg));
   assign bpv      = bit_en && ((sym == SYM_BOTH) || (same && !legit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_p   <= 1'b0;
         last_neg <= 1'b0;
         have_v   <= 1'b0;
         v_neg    <= 1'b0;
      end else if (bit_en && is_pulse) begin
         have_p   <= 1'b1;
         last_neg <= pol_neg;
         if (same) begin
            have_v <= 1'b1;
            v_neg  <= pol_neg;
         end
      end
   end
endmodule

// File: rtl/lcv_counter.sv
module lcv_counter #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   localparam int NB    = CNT_W / BYTE_W,
   localparam int SELW  = (NB > 2) ? $clog2(NB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              wr_en,
   input  logic [SELW-1:0]   wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              lsb_irq_en,
   input  logic              wrap_irq_en,
   output logic [CNT_W-1:0]  count,
   output logic              irq_lsb,
   output logic              irq_wrap
);
   localparam int STG_W = CNT_W - BYTE_W;

   logic [STG_W-1:0] stage;
   logic             commit, step;

   assign commit = wr_en && (wr_sel == SELW'(NB - 1));
   assign step   = inc && !commit;

   generate
      for (genvar k = 0; k < NB - 1; k++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n)
               stage[k*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && wr_sel == SELW'(k))
               stage[k*BYTE_W +: BYTE_W] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count    <= '0;
         irq_lsb  <= 1'b0;
         irq_wrap <= 1'b0;
      end else begin
         irq_lsb  <= step && lsb_irq_en;
         irq_wrap <= step && wrap_irq_en && (&count);
         if (commit)    count <= {wr_data, stage};
         else if (step) count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/lcv_monitor.sv
module lcv_monitor
   import lcv_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int BYTE_W    = 8,
   parameter int HDB3_ZMAX = 3,
   parameter int AMI_ZMAX  = 15,
   localparam int NB       = CNT_W / BYTE_W,
   localparam int SELW     = (NB > 2) ? $clog2(NB) : 1,
   localparam int ZW       = $clog2(AMI_ZMAX + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              rx_pos,
   input  logic              rx_neg,
   input  logic              hdb3_en,
   input  logic              exz_en,
   input  logic              oof_hold_en,
   input  logic              sync_lost,
   input  logic              wr_en,
   input  logic [SELW-1:0]   wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              lsb_irq_en,
   input  logic              wrap_irq_en,
   output logic [CNT_W-1:0]  count,
   output logic              irq_lsb,
   output logic              irq_wrap
);
   generate
      if ((CNT_W % BYTE_W) != 0 || NB < 2) begin : g_bad_width
         $error("lcv_monitor: CNT_W must be a multiple of BYTE_W, at least two bytes");
      end
   endgenerate

   lcv_sym_e      sym;
   logic [ZW-1:0] zrun;
   logic          exz_hit, bpv, hold, inc;

   assign sym  = lcv_sym(rx_pos, rx_neg);
   assign hold = oof_hold_en && sync_lost;
   // violations only occur on pulse bits and zero-run hits on zero bits; OR merges to one step
   assign inc  = (bpv || (exz_en && exz_hit)) && !hold;

   lcv_zero_run #(.HDB3_ZMAX(HDB3_ZMAX), .AMI_ZMAX(AMI_ZMAX)) zrun_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sym(sym),
      .hdb3_en(hdb3_en), .zrun(zrun), .exz_hit(exz_hit)
   );

   lcv_bpv_detect #(.ZW(ZW)) bpv_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sym(sym),
      .hdb3_en(hdb3_en), .zrun(zrun), .bpv(bpv)
   );

   lcv_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .inc(inc), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .lsb_irq_en(lsb_irq_en), .wrap_irq_en(wrap_irq_en),
      .count(count), .irq_lsb(irq_lsb), .irq_wrap(irq_wrap)
   );
endmodule

// File: rtl/lcv_monitor_chk.sv
module lcv_monitor_chk #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int SELW   = 1,
   localparam int NB    = CNT_W / BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              oof_hold_en,
   input logic              sync_lost,
   input logic              wr_en,
   input logic [SELW-1:0]   wr_sel,
   input logic [BYTE_W-1:0] wr_data,
   input logic [CNT_W-1:0]  count,
   input logic              irq_lsb,
   input logic              irq_wrap
);
   logic commit;
   assign commit = wr_en && (wr_sel == SELW'(NB - 1));

   p_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

   p_hold_oof_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (oof_hold_en && sync_lost && !commit) |=> $stable(count));

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_en && !commit) |=> $stable(count));

   p_stage_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SELW'(0) && !bit_en) |=> $stable(count));

   p_commit_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (count[CNT_W-1 -: BYTE_W] == $past(wr_data)) && !irq_lsb && !irq_wrap);

   p_lsb_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lsb |-> (count[0] != $past(count[0])));

   p_wrap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wrap |-> (count == '0) && (&$past(count)));
endmodule

bind lcv_monitor lcv_monitor_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .SELW(SELW)) chk_i (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .oof_hold_en(oof_hold_en),
   .sync_lost(sync_lost), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .count(count), .irq_lsb(irq_lsb), .irq_wrap(irq_wrap)
);

// File: tb/lcv_monitor_tb_top.sv
module lcv_monitor_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 0, rx_pos = 0, rx_neg = 0, hdb3_en = 0, exz_en = 0;
   logic oof_hold_en = 0, sync_lost = 0, wr_en = 0, lsb_irq_en = 1, wrap_irq_en = 1;
   logic [0:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic [15:0] count;
   logic irq_lsb, irq_wrap;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference model state
   bit m_hp = 0, m_lp = 0, m_hv = 0, m_vp = 0;
   int m_z = 0;
   int m_cnt = 0;
   int m_stage = 0;
   bit e_lsb = 0, e_wrap = 0;

   always #4 clk = ~clk;

   lcv_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
      .hdb3_en(hdb3_en), .exz_en(exz_en), .oof_hold_en(oof_hold_en),
      .sync_lost(sync_lost), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .lsb_irq_en(lsb_irq_en), .wrap_irq_en(wrap_irq_en),
      .count(count), .irq_lsb(irq_lsb), .irq_wrap(irq_wrap)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, model the edge, compare at the next negedge
   task automatic cyc(input string tag, input bit be, input bit p, input bit n,
                      input bit we = 0, input bit ws = 0, input int wd = 0);
      bit bpv, exz, inc, pol, same, legit, commit;
      int thr;
      bit_en = be; rx_pos = p; rx_neg = n;
      wr_en = we; wr_sel = ws; wr_data = wd[7:0];
      bpv = 0; exz = 0;
      if (be) begin
         if (p && n) begin
            bpv = 1; m_z = 0;
         end else if (p || n) begin
            pol = n;
            same = m_hp && (pol == m_lp);
            if (same) begin
               legit = hdb3_en && (m_z == 2 || m_z == 3) && (!m_hv || pol != m_vp);
               bpv = !legit;
               m_hv = 1; m_vp = pol;
            end
            m_hp = 1; m_lp = pol; m_z = 0;
         end else begin
            m_z++;
            thr = hdb3_en ? 3 : 15;
            exz = (m_z == thr + 1);
         end
      end
      inc = (bpv || (exz_en && exz)) && !(oof_hold_en && sync_lost);
      commit = we && ws;
      e_lsb = 0; e_wrap = 0;
      if (commit) m_cnt = (wd & 8'hFF) * 256 + m_stage;
      else if (inc) begin
         e_lsb = lsb_irq_en;
         e_wrap = wrap_irq_en && (m_cnt == 16'hFFFF);
         m_cnt = (m_cnt + 1) & 16'hFFFF;
      end
      if (we && !ws) m_stage = wd & 8'hFF;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "count", int'(count), m_cnt);
      chk(tag, "irq_lsb", int'(irq_lsb), int'(e_lsb));
      chk(tag, "irq_wrap", int'(irq_wrap), int'(e_wrap));
   endtask

   task automatic zeros(input string tag, input int k);
      for (int i = 0; i < k; i++) cyc(tag, 1, 0, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "count", int'(count), 0);
      chk("R1", "irq_lsb", int'(irq_lsb), 0);
      chk("R1", "irq_wrap", int'(irq_wrap), 0);

      // R2: AMI rules
      cyc("R2", 1, 1, 0); cyc("R2", 1, 0, 1); cyc("R2", 1, 1, 0);
      cyc("R2", 1, 0, 0); cyc("R2", 1, 0, 1);
      chk("R2", "alternating no count", int'(count), 0);
      cyc("R2", 1, 0, 1);
      chk("R2", "same polarity count", int'(count), 1);

      // R11: strobe low ignores pulses
      for (int i = 0; i < 4; i++) cyc("R11", 0, 1, 1);
      chk("R11", "gated hold", int'(count), 1);

      // R4: both flags, polarity kept (last is negative)
      cyc("R4", 1, 1, 1);
      chk("R4", "both flags", int'(count), 2);
      cyc("R4", 1, 1, 0);
      chk("R4", "polarity unchanged", int'(count), 2);

      // R3: HDB3 substitutions (previous violation negative)
      hdb3_en = 1;
      cyc("R3", 1, 0, 1); zeros("R3", 3); cyc("R3", 1, 0, 1);
      chk("R3", "repeat polarity counted", int'(count), 3);
      cyc("R3", 1, 1, 0); zeros("R3", 2); cyc("R3", 1, 1, 0);
      chk("R3", "B00V accepted", int'(count), 3);
      cyc("R3", 1, 0, 1); zeros("R3", 3); cyc("R3", 1, 0, 1);
      chk("R3", "000V accepted", int'(count), 3);
      cyc("R3", 1, 0, 1);
      chk("R3", "adjacent counted", int'(count), 4);

      // R5: excess zeros
      exz_en = 1;
      cyc("R5", 1, 1, 0); zeros("R5", 3);
      chk("R5", "three zeros ok", int'(count), 4);
      zeros("R5", 1);
      chk("R5", "fourth zero counts", int'(count), 5);
      zeros("R5", 12);
      chk("R5", "once per run", int'(count), 5);
      hdb3_en = 0;
      cyc("R5", 1, 0, 1); zeros("R5", 15);
      chk("R5", "fifteen zeros ok", int'(count), 5);
      zeros("R5", 5);
      chk("R5", "sixteenth zero counts", int'(count), 6);
      exz_en = 0;
      cyc("R5", 1, 1, 0); zeros("R5", 20);
      chk("R5", "disabled", int'(count), 6);

      // R7: hold on frame loss
      oof_hold_en = 1; sync_lost = 1;
      cyc("R7", 1, 1, 1); cyc("R7", 1, 1, 1);
      chk("R7", "held", int'(count), 6);
      sync_lost = 0;
      cyc("R7", 1, 1, 1);
      chk("R7", "released", int'(count), 7);
      oof_hold_en = 0;

      // R8: ordered byte load
      cyc("R8", 0, 0, 0, 1, 0, 8'h34);
      chk("R8", "low byte staged only", int'(count), 7);
      cyc("R8", 0, 0, 0, 1, 1, 8'h12);
      chk("R8", "commit", int'(count), 16'h1234);
      cyc("R8", 1, 1, 1, 1, 1, 8'hAB);
      chk("R8", "load beats event", int'(count), 16'hAB34);

      // R10 / R9: wrap and strobes
      cyc("R10", 0, 0, 0, 1, 0, 8'hFF); cyc("R10", 0, 0, 0, 1, 1, 8'hFF);
      cyc("R10", 1, 1, 1);
      chk("R10", "wrap strobe", int'(irq_wrap), 1);
      chk("R9", "lsb strobe", int'(irq_lsb), 1);
      cyc("R10", 0, 0, 0);
      chk("R10", "wrap one cycle", int'(irq_wrap), 0);
      wrap_irq_en = 0;
      cyc("R10", 0, 0, 0, 1, 1, 8'hFF);
      cyc("R10", 1, 1, 1);
      chk("R10", "wrap masked", int'(irq_wrap), 0);
      lsb_irq_en = 0;
      cyc("R9", 1, 1, 1);
      chk("R9", "lsb masked", int'(irq_lsb), 0);
      lsb_irq_en = 1; wrap_irq_en = 1;

      // R6 (and R2, R3, R5): random stream against the model
      exz_en = 1;
      for (int i = 0; i < 6000; i++) begin
         int r;
         if (i % 1500 == 0) hdb3_en = ~hdb3_en;
         r = $urandom % 16;
         if (r < 9)       cyc("R6", 1, 0, 0);
         else if (r < 12) cyc("R6", 1, 1, 0);
         else if (r < 15) cyc("R6", 1, 0, 1);
         else             cyc("R6", 1, 1, 1);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule